// File: doc/BRIEF.md
# Fractional-Divider Pixel Bit Serializer

This block turns a stream of 32-bit frames into one serial data line with a matching bit clock. It is used to drive strings of self-clocked LEDs. Logic upstream encodes every pixel bit as a short pattern of fast serial bits and packs those patterns into frames. The bit rate comes from the system clock through a divide ratio of `2*div_i + odd_i`. An odd ratio is therefore possible, which lets common system clocks reach a bit rate such as 6.4 MHz. For example, 160 MHz with a divisor of 12 and the odd bit set divides by 25 and gives exactly 6.4 MHz.

Each frame holds two 16-bit channel words and is sent MSB first. A channel-select line marks the second word. The frame rate is the bit rate divided by 32. Frames are taken with a valid/ready handshake exactly at each frame boundary, so no gap appears between frames. If no frame is waiting at a boundary, the block sends a frame of zeros and raises a sticky underrun flag. A divisor below 2 is treated as an invalid setting, and the block stays idle.

Top module: `pix_bit_serializer`

## Requirements
- R1: After reset, and on any cycle while `enable` is low, `sck`, `sdo`, `ws` and `frame_ready` are low. `underrun` is low after reset.
- R2: While running, consecutive rising edges of `sck` are exactly `2*div_i + odd_i` clock cycles apart, including across frame boundaries.
- R3: Each `sck` pulse is high for `div_i + odd_i` cycles and low for `div_i` cycles.
- R4: A frame is sent as 32 bits, MSB first. `sdo` changes only while `sck` is low and is valid at each rising edge of `sck`.
- R5: `ws` is 0 during the first 16 bits of a frame (bits 31..16) and 1 during the last 16 bits (bits 15..0). It changes only together with a falling `sck`.
- R6: `frame_ready` is high for one cycle on the first active cycle after start-up and on the last cycle of each frame. Accepted frames therefore start exactly `32*(2*div_i + odd_i)` cycles apart.
- R7: If `frame_valid` is low when a frame is due, 32 zero bits are sent and `underrun` goes to 1. `underrun` stays at 1 until reset.
- R8: With `div_i` below 2, the block behaves as if disabled: `sck` stays low and no frame is accepted.
- R9: Dropping `enable` returns all outputs to idle by the next cycle. Raising `enable` again starts a new frame at its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the serializer |
| div_i | input | DIV_W | Integer part of the divide ratio |
| odd_i | input | 1 | Adds one cycle to the ratio, lengthening the high phase |
| frame_data | input | 32 | Frame: bits 31..16 are the first word, bits 15..0 the second |
| frame_valid | input | 1 | A frame is offered |
| frame_ready | output | 1 | A frame is taken on this cycle |
| sdo | output | 1 | Serial data |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Channel select, 0 for the first word |
| underrun | output | 1 | Sticky flag: a frame was due with none offered |

## Verification
Every bit is observed at the ports, so an error in the phase counter shows up as a wrong edge spacing within one bit period. A slip in the bit index shows up in `ws` within one word, and in a wrong frame value within 32 bits. Edge spacing is measured across frame boundaries, which makes a one-cycle gap or overlap at the load point show up in the first bit of the next frame. A handshake that takes a frame early or late shifts the data seen by the scoreboard and the spacing of the `frame_ready` pulses.

// File: rtl/pix_bit_serializer.sv
module pix_bit_serializer #(
  parameter int DIV_W = 8,
  parameter int CH_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_i,
  input  logic             odd_i,
  input  logic [2*CH_W-1:0] frame_data,
  input  logic             frame_valid,
  output logic             frame_ready,
  output logic             sdo,
  output logic             sck,
  output logic             ws,
  output logic             underrun
);
  localparam int FRAME_W = 2 * CH_W;
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam int CNT_W   = DIV_W + 1;

  logic               running;
  logic [CNT_W-1:0]   cnt;
  logic [BIT_W-1:0]   bidx;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   last;
  logic               active, bit_end, frame_end, load;

  assign active    = enable && (div_i >= DIV_W'(2));
  assign last      = CNT_W'({div_i, 1'b0}) + CNT_W'(odd_i) - CNT_W'(1);
  assign bit_end   = cnt >= last;
  assign frame_end = bit_end && (bidx == BIT_W'(FRAME_W - 1));
  assign load      = active && (!running || frame_end);

  assign frame_ready = load;
  assign sdo = shreg[FRAME_W-1];
  assign sck = running && (cnt >= CNT_W'(div_i));
  assign ws  = running && (bidx >= BIT_W'(CH_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      bidx    <= '0;
      shreg   <= '0;
    end else if (!active) begin
      running <= 1'b0;
      cnt     <= '0;
      bidx    <= '0;
      shreg   <= '0;
    end else if (load) begin
      running <= 1'b1;
      cnt     <= '0;
      bidx    <= '0;
      shreg   <= frame_valid ? frame_data : '0;
    end else if (bit_end) begin
      cnt     <= '0;
      bidx    <= bidx + BIT_W'(1);
      shreg   <= {shreg[FRAME_W-2:0], 1'b0};
    end else begin
      cnt     <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    underrun <= 1'b0;
    else if (load && !frame_valid) underrun <= 1'b1;
  end

  a_r1_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sck && !sdo && !ws));
  a_r4_sdo_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(sdo));
  a_r5_ws_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !$stable(ws)) |-> $fell(sck));
  a_r6_first_bit_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ready && frame_valid) |=> (sdo == $past(frame_data[FRAME_W-1])));
  a_r7_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);
  a_r8_bad_div_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i < DIV_W'(2)) |-> !frame_ready);
endmodule

// File: tb/test_pix_bit_serializer.sv
`timescale 1ns/1ps
module test_pix_bit_serializer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [7:0] div_i = 8'd2;
  logic odd_i = 1'b0;
  logic [31:0] frame_data = '0;
  logic frame_valid = 1'b0;
  logic frame_ready, sdo, sck, ws, underrun;

  always #2.5 clk = ~clk;

  pix_bit_serializer i_pix_bit_serializer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_i(div_i), .odd_i(odd_i),
    .frame_data(frame_data), .frame_valid(frame_valid), .frame_ready(frame_ready),
    .sdo(sdo), .sck(sck), .ws(ws), .underrun(underrun));

  int checks = 0;
  int errors = 0;
  logic [31:0] tx[$];
  logic [31:0] expq[$];
  int done_cnt = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    frame_valid = tx.size() > 0;
    frame_data  = (tx.size() > 0) ? tx[0] : 32'h0;
  end

  longint cyc = 0;
  longint last_acc = -1;
  always @(posedge clk) begin
    cyc++;
    if (!enable) last_acc = -1;
    else if (frame_ready) begin
      if (last_acc >= 0)
        chk(cyc - last_acc == 32 * (2 * div_i + odd_i), "R6 frame spacing",
            cyc - last_acc, 32 * (2 * div_i + odd_i));
      last_acc = cyc;
      if (frame_valid) void'(tx.pop_front());
    end
  end

  int bits = 0, sr = 0, hc = 0, lc = 0;
  bit have = 0, prev = 0;
  logic [31:0] word;
  always @(negedge clk) begin
    if (!enable) begin
      bits = 0; sr = 0; hc = 0; lc = 0; have = 0; prev = 0;
    end else begin
      sr++;
      if (sck && !prev) begin
        if (have) begin
          chk(sr == 2 * div_i + odd_i, "R2 period", sr, 2 * div_i + odd_i);
          chk(lc == div_i, "R3 low phase", lc, div_i);
        end
        have = 1; sr = 0; lc = 0;
        chk(ws == (bits >= 16), "R5 channel select", ws, bits >= 16);
        word = {word[30:0], sdo};
        bits++;
        if (bits == 32) begin
          bits = 0;
          if (expq.size() == 0) chk(0, "R4 unexpected frame", word, 0);
          else begin
            logic [31:0] e;
            e = expq.pop_front();
            chk(word == e, "R4 frame data", word, e);
          end
          done_cnt++;
        end
      end
      if (!sck && prev) begin
        chk(hc == div_i + odd_i, "R3 high phase", hc, div_i + odd_i);
        hc = 0;
      end
      if (sck) hc++; else lc++;
      prev = sck;
    end
  end

  task automatic run_phase(input int d, input bit o, input int nframes);
    int target;
    target = done_cnt + nframes;
    @(negedge clk);
    div_i = 8'(d); odd_i = o;
    enable = 1'b1;
    wait (done_cnt >= target);
    enable = 1'b0;
    @(negedge clk);
    chk(!sck && !sdo && !ws, "R9 idle after disable", {sck, sdo, ws}, 0);
  endtask

  task automatic push(input logic [31:0] f);
    tx.push_back(f);
    expq.push_back(f);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sck && !sdo && !ws && !frame_ready && !underrun, "R1 reset state",
        {sck, sdo, ws, frame_ready, underrun}, 0);

    push(32'hA5C3_0F01); push(32'h8000_0001); push(32'h1234_FEDC);
    run_phase(2, 0, 3);
    chk(underrun == 0, "R7 no false underrun", underrun, 0);

    push(32'hFFFF_0000); push(32'h0000_FFFF);
    run_phase(3, 1, 2);

    push(32'h5A5A_C3C3);
    run_phase(12, 1, 1);
    chk(underrun == 0, "R7 no false underrun", underrun, 0);

    push(32'hDEAD_BEEF);
    expq.push_back(32'h0);
    run_phase(2, 1, 2);
    chk(underrun == 1, "R7 underrun set", underrun, 1);

    push(32'h0F0F_7E81);
    run_phase(4, 0, 1);
    chk(underrun == 1, "R7 underrun sticky", underrun, 1);

    tx.push_back(32'h1111_2222);
    @(negedge clk);
    div_i = 8'd1; odd_i = 1'b1; enable = 1'b1;
    begin
      bit quiet = 1;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (sck || frame_ready) quiet = 0;
      end
      chk(quiet, "R8 bad divisor idle", !quiet, 0);
      chk(tx.size() == 1, "R8 no frame taken", tx.size(), 1);
    end
    enable = 1'b0;
    tx.delete();
    @(negedge clk);
    chk(!sck && !frame_ready, "R1 idle when disabled", {sck, frame_ready}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule